// File: doc/BRIEF.md
# HS400 Mode-Switch Sequencer

This block walks a card host interface from tuned high-speed operation into 8-bit HS400 operation without software stepping through each control bit. A one-cycle start pulse captures the clock division found by tuning and a read-transaction flag. The sequencer then slows the card clock and parks the tuning block, and asks for the DDR and HS400 card switches over two request/acknowledge handshakes. After that it gates and regates the card clock around the HS400 configuration, brings up the delay-locked loop and waits for its lock, sets the window adjust, and flushes the asynchronous FIFO while the card clock is stopped.

Each status wait (clock stable, delay-chain lock, flush complete) is polled on a fixed interval derived from the reference clock frequency, and each has the same overall timeout. A wait that runs out aborts the sequence with an error pulse and a code naming the step. A clean run ends with a one-cycle done pulse, and the control outputs stay in their HS400 settings.

Top module: `hs400_seq`

## Requirements
- R1: After reset: busy, ddr_req, hs_req, tb_en, hs400_sel, cmd_clk_sel, dll_en, dll_fast, wndw_adj, fifo_flush, flow_ctl, done, err are 0, err_code is 0, clk_en is 1 and clk_div holds the slow divider LS_DIV = ceil(BASE_HZ / LS_HZ) (16 at defaults).
- R2: A start pulse while idle captures tune_div for later reuse and sets flow_ctl to read_xfer in the following cycle. A start pulse while busy has no effect on the run.
- R3: The cycle after start, clk_div is set to LS_DIV and tb_en is cleared, one cycle before ddr_req rises.
- R4: ddr_req is held until ddr_ack is seen, then hs_req is held until hs_ack is seen. The two requests are never high together, and tb_en is set again one cycle after hs_ack.
- R5: The card clock is gated (clk_en low) and clock stability is awaited. The captured division is then loaded into clk_div with hs400_sel and cmd_clk_sel set while the clock is still gated. One cycle later clk_en returns to 1 and stability is awaited again.
- R6: dll_en is then set, with dll_fast set only when BASE_HZ / captured division is exactly HS_HZ (200 MHz). wndw_adj is set only after dll_lock has been seen.
- R7: Finish: clk_en cleared, stability awaited, fifo_flush set (only while the clock is gated) and held until flush_done. fifo_flush then clears in the same cycle clk_en returns to 1, stability is awaited, and done pulses for one cycle.
- R8: Status inputs are sampled only on every POLL_CYC-th cycle of a wait, POLL_CYC = REF_HZ/1e6 * POLL_US. A step advances at the end of the first poll cycle where its status is 1.
- R9: A wait with no status at any of TICKS = WAIT_MS*1000/POLL_US polls ends after POLL_CYC*TICKS cycles with a one-cycle err pulse, fifo_flush cleared, a return to idle and err_code naming the step: 1 first gate, 2 clock restart, 3 DLL lock, 4 second gate, 5 flush, 6 final restart.
- R10: done and err are never high together. err_code holds its value while idle until the next accepted start clears it.
- R11: busy is 1 from the cycle after an accepted start until the cycle in which done or err pulses, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin the switch |
| tune_div | input | DIV_W | Clock division chosen by tuning |
| read_xfer | input | 1 | Switch is for read transactions (flow-control timing bit) |
| ddr_ack | input | 1 | Card accepted the 8-bit DDR switch |
| hs_ack | input | 1 | Card accepted the HS400 switch |
| clk_stable | input | 1 | Card clock stable status |
| dll_lock | input | 1 | Delay chain locked status |
| flush_done | input | 1 | FIFO flush has completed (flush bit self-cleared) |
| busy | output | 1 | Sequence in progress |
| ddr_req | output | 1 | Request the 8-bit DDR card switch |
| hs_req | output | 1 | Request the HS400 card switch |
| tb_en | output | 1 | Tuning block enable |
| clk_en | output | 1 | Card clock enable |
| clk_div | output | DIV_W | Card clock division |
| hs400_sel | output | 1 | HS400 mode select |
| cmd_clk_sel | output | 1 | Command clock control |
| dll_en | output | 1 | DLL enable |
| dll_fast | output | 1 | DLL frequency select (fast chain) |
| wndw_adj | output | 1 | HS400 window adjust |
| fifo_flush | output | 1 | Asynchronous FIFO flush request |
| flow_ctl | output | 1 | Read flow-control timing bit |
| done | output | 1 | One-cycle pulse on success |
| err | output | 1 | One-cycle pulse on timeout |
| err_code | output | 3 | Step that timed out, held until next start |

## Verification
A wrong internal step shows at once at the ports, because every step owns a distinct pattern of the control outputs and request lines. So a skipped or reordered step differs from the reference model in the cycle it happens. A wrong poll counter shows as an edge of hs400_sel, dll_en, wndw_adj or fifo_flush moved by whole poll intervals. A wrong timeout limit shows as an err pulse early or late by the same unit, and a wrong captured divider shows in clk_div and dll_fast at the restart step. The bench compares every output each cycle, so the first divergent cycle is reported.

// File: rtl/hs400_pkg.sv
package hs400_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SLOW,
    ST_DDR,
    ST_HS,
    ST_TBON,
    ST_OFF1,
    ST_WSTB1,
    ST_ON1,
    ST_WSTB2,
    ST_WLOCK,
    ST_OFF2,
    ST_WSTB3,
    ST_WFLUSH,
    ST_WSTB4
  } seq_state_e;

  typedef enum logic [2:0] {
    EC_NONE    = 3'd0,
    EC_GATE1   = 3'd1,
    EC_RESTART = 3'd2,
    EC_DLL     = 3'd3,
    EC_GATE2   = 3'd4,
    EC_FLUSH   = 3'd5,
    EC_FINAL   = 3'd6
  } err_code_e;

  // one-cycle actions issued by the sequencer to the control bank
  typedef struct packed {
    logic ld_lat;
    logic go_slow;
    logic tb_on;
    logic clk_off;
    logic clk_on;
    logic hs_cfg;
    logic dll_cfg;
    logic wndw_set;
    logic flush_set;
    logic flush_end;
    logic fin_ok;
    logic fail;
  } act_t;

endpackage

// File: rtl/hs400_poll_timer.sv
module hs400_poll_timer #(
  parameter int POLL_CYC = 1000,
  parameter int TICKS    = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick,
  output logic expire
);
  localparam int CW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tk_q, tk_d;

  always_comb begin
    tick   = run && (cnt_q == CW'(POLL_CYC - 1));
    expire = tick && (tk_q == TW'(TICKS - 1));
  end

  always_comb begin
    cnt_d = cnt_q;
    tk_d  = tk_q;
    if (!run || restart) begin
      cnt_d = '0;
      tk_d  = '0;
    end else if (tick) begin
      cnt_d = '0;
      tk_d  = tk_q + TW'(1);
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tk_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      tk_q  <= tk_d;
    end
  end

  // R8: polls of one wait are POLL_CYC cycles apart
  assert_poll_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !restart && POLL_CYC > 1) |=> !tick);

endmodule

// File: rtl/hs400_ctl_bank.sv
module hs400_ctl_bank
  import hs400_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int LS_DIV   = 16,
  parameter int HS_DIV   = 4,
  parameter bit HS_EXACT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_t             act,
  input  err_code_e        ecode,
  input  logic [DIV_W-1:0] tune_div,
  input  logic             read_xfer,
  output logic             tb_en,
  output logic             clk_en,
  output logic [DIV_W-1:0] clk_div,
  output logic             hs400_sel,
  output logic             cmd_clk_sel,
  output logic             dll_en,
  output logic             dll_fast,
  output logic             wndw_adj,
  output logic             fifo_flush,
  output logic             flow_ctl,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);

  logic [DIV_W-1:0] lat_q, lat_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic tb_q, tb_d, ce_q, ce_d, hs_q, hs_d, cmd_q, cmd_d;
  logic dll_q, dll_d, fast_q, fast_d, wa_q, wa_d, fl_q, fl_d;
  logic flow_q, flow_d, done_q, done_d, err_q, err_d;
  logic [2:0] code_q, code_d;
  logic lat_is_hs;

  always_comb lat_is_hs = HS_EXACT && (lat_q == DIV_W'(HS_DIV));

  always_comb begin
    lat_d  = lat_q;
    div_d  = div_q;
    tb_d   = tb_q;
    ce_d   = ce_q;
    hs_d   = hs_q;
    cmd_d  = cmd_q;
    dll_d  = dll_q;
    fast_d = fast_q;
    wa_d   = wa_q;
    fl_d   = fl_q;
    flow_d = flow_q;
    code_d = code_q;
    done_d = act.fin_ok;
    err_d  = act.fail;
    if (act.ld_lat) begin
      lat_d  = tune_div;
      flow_d = read_xfer;
      code_d = 3'd0;
    end
    if (act.go_slow) begin
      div_d = DIV_W'(LS_DIV);
      tb_d  = 1'b0;
    end
    if (act.tb_on)   tb_d = 1'b1;
    if (act.clk_off) ce_d = 1'b0;
    if (act.clk_on)  ce_d = 1'b1;
    if (act.hs_cfg) begin
      div_d = lat_q;
      hs_d  = 1'b1;
      cmd_d = 1'b1;
    end
    if (act.dll_cfg) begin
      dll_d  = 1'b1;
      fast_d = lat_is_hs;
    end
    if (act.wndw_set)  wa_d = 1'b1;
    if (act.flush_set) fl_d = 1'b1;
    if (act.flush_end) begin
      fl_d = 1'b0;
      ce_d = 1'b1;
    end
    if (act.fail) begin
      fl_d   = 1'b0;
      code_d = 3'(ecode);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      div_q  <= DIV_W'(LS_DIV);
      tb_q   <= 1'b0;
      ce_q   <= 1'b1;
      hs_q   <= 1'b0;
      cmd_q  <= 1'b0;
      dll_q  <= 1'b0;
      fast_q <= 1'b0;
      wa_q   <= 1'b0;
      fl_q   <= 1'b0;
      flow_q <= 1'b0;
      code_q <= 3'd0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      div_q  <= div_d;
      tb_q   <= tb_d;
      ce_q   <= ce_d;
      hs_q   <= hs_d;
      cmd_q  <= cmd_d;
      dll_q  <= dll_d;
      fast_q <= fast_d;
      wa_q   <= wa_d;
      fl_q   <= fl_d;
      flow_q <= flow_d;
      code_q <= code_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    tb_en       = tb_q;
    clk_en      = ce_q;
    clk_div     = div_q;
    hs400_sel   = hs_q;
    cmd_clk_sel = cmd_q;
    dll_en      = dll_q;
    dll_fast    = fast_q;
    wndw_adj    = wa_q;
    fifo_flush  = fl_q;
    flow_ctl    = flow_q;
    done        = done_q;
    err         = err_q;
    err_code    = code_q;
  end

  assert_flush_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fl_q |-> !ce_q);
  assert_hs_cfg_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> !ce_q);
  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q));
  assert_err_has_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (code_q != 3'd0));

endmodule

// File: rtl/hs400_fsm.sv
module hs400_fsm
  import hs400_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      ddr_ack,
  input  logic      hs_ack,
  input  logic      clk_stable,
  input  logic      dll_lock,
  input  logic      flush_done,
  input  logic      tick,
  input  logic      expire,
  output act_t      act,
  output err_code_e ecode,
  output logic      busy,
  output logic      ddr_req,
  output logic      hs_req,
  output logic      run,
  output logic      restart
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    act     = '0;
    ecode   = EC_NONE;
    unique case (state_q)
      ST_IDLE: if (start) begin
        act.ld_lat = 1'b1;
        state_d    = ST_SLOW;
      end
      ST_SLOW: begin
        act.go_slow = 1'b1;
        state_d     = ST_DDR;
      end
      ST_DDR: if (ddr_ack) state_d = ST_HS;
      ST_HS:  if (hs_ack)  state_d = ST_TBON;
      ST_TBON: begin
        act.tb_on = 1'b1;
        state_d   = ST_OFF1;
      end
      ST_OFF1: begin
        act.clk_off = 1'b1;
        state_d     = ST_WSTB1;
      end
      ST_WSTB1:
        if (tick && clk_stable) begin
          act.hs_cfg = 1'b1;
          state_d    = ST_ON1;
        end else if (expire) begin
          act.fail = 1'b1;
          ecode    = EC_GATE1;
          state_d  = ST_IDLE;
        end
      ST_ON1: begin
        act.clk_on = 1'b1;
        state_d    = ST_WSTB2;
      end
      ST_WSTB2:
        if (tick && clk_stable) begin
          act.dll_cfg = 1'b1;
          state_d     = ST_WLOCK;
        end else if (expire) begin
          act.fail = 1'b1;
          ecode    = EC_RESTART;
          state_d  = ST_IDLE;
        end
      ST_WLOCK:
        if (tick && dll_lock) begin
          act.wndw_set = 1'b1;
          state_d      = ST_OFF2;
        end else if (expire) begin
          act.fail = 1'b1;
          ecode    = EC_DLL;
          state_d  = ST_IDLE;
        end
      ST_OFF2: begin
        act.clk_off = 1'b1;
        state_d     = ST_WSTB3;
      end
      ST_WSTB3:
        if (tick && clk_stable) begin
          act.flush_set = 1'b1;
          state_d       = ST_WFLUSH;
        end else if (expire) begin
          act.fail = 1'b1;
          ecode    = EC_GATE2;
          state_d  = ST_IDLE;
        end
      ST_WFLUSH:
        if (tick && flush_done) begin
          act.flush_end = 1'b1;
          state_d       = ST_WSTB4;
        end else if (expire) begin
          act.fail = 1'b1;
          ecode    = EC_FLUSH;
          state_d  = ST_IDLE;
        end
      ST_WSTB4:
        if (tick && clk_stable) begin
          act.fin_ok = 1'b1;
          state_d    = ST_IDLE;
        end else if (expire) begin
          act.fail = 1'b1;
          ecode    = EC_FINAL;
          state_d  = ST_IDLE;
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    busy    = (state_q != ST_IDLE);
    ddr_req = (state_q == ST_DDR);
    hs_req  = (state_q == ST_HS);
    run     = (state_q == ST_WSTB1) || (state_q == ST_WSTB2) ||
              (state_q == ST_WLOCK) || (state_q == ST_WSTB3) ||
              (state_q == ST_WFLUSH) || (state_q == ST_WSTB4);
    restart = (state_d != state_q);
  end

  assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ddr_req && hs_req));
  assert_ddr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_req && !ddr_ack) |=> ddr_req);
  assert_start_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

endmodule

// File: rtl/hs400_seq.sv
module hs400_seq
  import hs400_pkg::*;
#(
  parameter int REF_HZ  = 100_000_000,
  parameter int POLL_US = 10,
  parameter int WAIT_MS = 20,
  parameter int BASE_HZ = 800_000_000,
  parameter int HS_HZ   = 200_000_000,
  parameter int LS_HZ   = 52_000_000,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DIV_W-1:0] tune_div,
  input  logic             read_xfer,
  input  logic             ddr_ack,
  input  logic             hs_ack,
  input  logic             clk_stable,
  input  logic             dll_lock,
  input  logic             flush_done,
  output logic             busy,
  output logic             ddr_req,
  output logic             hs_req,
  output logic             tb_en,
  output logic             clk_en,
  output logic [DIV_W-1:0] clk_div,
  output logic             hs400_sel,
  output logic             cmd_clk_sel,
  output logic             dll_en,
  output logic             dll_fast,
  output logic             wndw_adj,
  output logic             fifo_flush,
  output logic             flow_ctl,
  output logic             done,
  output logic             err,
  output logic [2:0]       err_code
);
  localparam int POLL_RAW = (REF_HZ / 1_000_000) * POLL_US;
  localparam int POLL_CYC = (POLL_RAW > 0) ? POLL_RAW : 1;
  localparam int TICK_RAW = (WAIT_MS * 1000) / POLL_US;
  localparam int TICKS    = (TICK_RAW > 0) ? TICK_RAW : 1;
  localparam int LS_DIV   = (BASE_HZ + LS_HZ - 1) / LS_HZ;
  localparam int HS_DIV   = BASE_HZ / HS_HZ;
  localparam bit HS_EXACT = ((BASE_HZ % HS_HZ) == 0);

  logic [1:0] rsync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  always_comb rst_core_n = rsync_q[1];

  act_t      act;
  err_code_e ecode;
  logic      run, restart, tick, expire;

  hs400_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (start),
    .ddr_ack    (ddr_ack),
    .hs_ack     (hs_ack),
    .clk_stable (clk_stable),
    .dll_lock   (dll_lock),
    .flush_done (flush_done),
    .tick       (tick),
    .expire     (expire),
    .act        (act),
    .ecode      (ecode),
    .busy       (busy),
    .ddr_req    (ddr_req),
    .hs_req     (hs_req),
    .run        (run),
    .restart    (restart)
  );

  hs400_poll_timer #(
    .POLL_CYC (POLL_CYC),
    .TICKS    (TICKS)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .run     (run),
    .restart (restart),
    .tick    (tick),
    .expire  (expire)
  );

  hs400_ctl_bank #(
    .DIV_W    (DIV_W),
    .LS_DIV   (LS_DIV),
    .HS_DIV   (HS_DIV),
    .HS_EXACT (HS_EXACT)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .act         (act),
    .ecode       (ecode),
    .tune_div    (tune_div),
    .read_xfer   (read_xfer),
    .tb_en       (tb_en),
    .clk_en      (clk_en),
    .clk_div     (clk_div),
    .hs400_sel   (hs400_sel),
    .cmd_clk_sel (cmd_clk_sel),
    .dll_en      (dll_en),
    .dll_fast    (dll_fast),
    .wndw_adj    (wndw_adj),
    .fifo_flush  (fifo_flush),
    .flow_ctl    (flow_ctl),
    .done        (done),
    .err         (err),
    .err_code    (err_code)
  );

  assert_wndw_after_lock_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(wndw_adj) |-> ($past(dll_lock) && dll_en));
  assert_slow_before_ddr_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(ddr_req) |-> (!tb_en && clk_div == DIV_W'(LS_DIV)));

endmodule

// File: tb/sim_hs400_seq.sv
module sim_hs400_seq;
  localparam int DIV_W   = 8;
  localparam int POLL    = 10;
  localparam int TICKS   = 100;
  localparam int BASE_HZ = 800_000_000;
  localparam int HS_HZ   = 200_000_000;
  localparam int LS_DIV  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [DIV_W-1:0] tune_div = '0;
  logic read_xfer = 1'b0;
  logic ddr_ack = 1'b0, hs_ack = 1'b0;
  logic clk_stable = 1'b1, dll_lock = 1'b0, flush_done = 1'b0;
  logic busy, ddr_req, hs_req, tb_en, clk_en, hs400_sel, cmd_clk_sel;
  logic dll_en, dll_fast, wndw_adj, fifo_flush, flow_ctl, done, err;
  logic [DIV_W-1:0] clk_div;
  logic [2:0] err_code;

  always #4 clk = ~clk;

  hs400_seq #(
    .REF_HZ(1_000_000), .POLL_US(10), .WAIT_MS(1),
    .BASE_HZ(BASE_HZ), .HS_HZ(HS_HZ), .LS_HZ(52_000_000), .DIV_W(DIV_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tune_div(tune_div),
    .read_xfer(read_xfer), .ddr_ack(ddr_ack), .hs_ack(hs_ack),
    .clk_stable(clk_stable), .dll_lock(dll_lock), .flush_done(flush_done),
    .busy(busy), .ddr_req(ddr_req), .hs_req(hs_req), .tb_en(tb_en),
    .clk_en(clk_en), .clk_div(clk_div), .hs400_sel(hs400_sel),
    .cmd_clk_sel(cmd_clk_sel), .dll_en(dll_en), .dll_fast(dll_fast),
    .wndw_adj(wndw_adj), .fifo_flush(fifo_flush), .flow_ctl(flow_ctl),
    .done(done), .err(err), .err_code(err_code)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // responder settings
  int stb_lat = 3, lock_lat = 25, fl_lat = 5, ack_lat = 2, stuck = 0;

  task automatic report;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // watchdog
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      report();
    end
  end

  // ---------------- environment responders ----------------
  bit prev_en = 1'b1;
  int stb_cnt = 0, lock_cnt = 0, fl_cnt = 0, ack_cnt = 0;

  function automatic bit stuck_now();
    case (stuck)
      1: return !clk_en && !hs400_sel;
      2: return clk_en && hs400_sel && !dll_en;
      4: return !clk_en && wndw_adj && !fifo_flush;
      6: return clk_en && wndw_adj;
      default: return 1'b0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_en = 1'b1; stb_cnt = 0; lock_cnt = 0; fl_cnt = 0; ack_cnt = 0;
      clk_stable <= 1'b1; dll_lock <= 1'b0; flush_done <= 1'b0;
      ddr_ack <= 1'b0; hs_ack <= 1'b0;
    end else begin
      if (clk_en != prev_en) begin
        stb_cnt = stb_lat;
        prev_en = clk_en;
      end
      clk_stable <= (stb_cnt == 0) && !stuck_now();
      if (stb_cnt > 0) stb_cnt--;
      if (dll_en) lock_cnt++; else lock_cnt = 0;
      dll_lock <= dll_en && (lock_cnt >= lock_lat) && (stuck != 3);
      if (fifo_flush) fl_cnt++; else fl_cnt = 0;
      flush_done <= fifo_flush && (fl_cnt >= fl_lat) && (stuck != 5);
      if (ddr_req || hs_req) begin
        if (ack_cnt >= ack_lat) begin
          ddr_ack <= ddr_req; hs_ack <= hs_req; ack_cnt = 0;
        end else begin
          ddr_ack <= 1'b0; hs_ack <= 1'b0; ack_cnt++;
        end
      end else begin
        ddr_ack <= 1'b0; hs_ack <= 1'b0; ack_cnt = 0;
      end
    end
  end

  // ---------------- reference model ----------------
  int rel = 0, mstep = 0, mwait = 0;
  int m_lat, m_div, m_code;
  bit m_tb, m_clk, m_hs, m_cmd, m_dll, m_fs, m_wa, m_fl, m_flow, m_done, m_err;

  task automatic mreset;
    mstep = 0; mwait = 0; m_lat = 0; m_div = LS_DIV; m_code = 0;
    m_tb = 0; m_clk = 1; m_hs = 0; m_cmd = 0; m_dll = 0; m_fs = 0;
    m_wa = 0; m_fl = 0; m_flow = 0; m_done = 0; m_err = 0;
  endtask

  // returns 1 = advance, 2 = timeout, 0 = keep waiting
  function automatic int mpoll(input bit cond);
    if ((mwait % POLL) == POLL - 1 && cond) return 1;
    if (mwait == POLL * TICKS - 1) return 2;
    return 0;
  endfunction

  task automatic mfail(input int code);
    m_err = 1; m_code = code; m_fl = 0; mstep = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel = 0; mreset();
    end else if (rel < 2) begin
      rel++; mreset();
    end else begin
      int r;
      m_done = 0; m_err = 0;
      case (mstep)
        0: if (start) begin
             m_lat = int'(tune_div); m_flow = read_xfer; m_code = 0; mstep = 1;
           end
        1: begin m_div = LS_DIV; m_tb = 0; mstep = 2; end
        2: if (ddr_ack) mstep = 3;
        3: if (hs_ack) mstep = 4;
        4: begin m_tb = 1; mstep = 5; end
        5: begin m_clk = 0; mstep = 6; mwait = 0; end
        6: begin
             r = mpoll(clk_stable);
             if (r == 1) begin m_div = m_lat; m_hs = 1; m_cmd = 1; mstep = 7; end
             else if (r == 2) mfail(1); else mwait++;
           end
        7: begin m_clk = 1; mstep = 8; mwait = 0; end
        8: begin
             r = mpoll(clk_stable);
             if (r == 1) begin
               m_dll = 1; m_fs = (BASE_HZ % HS_HZ == 0) && (m_lat * HS_HZ / 1000 == BASE_HZ / 1000);
               mstep = 9; mwait = 0;
             end else if (r == 2) mfail(2); else mwait++;
           end
        9: begin
             r = mpoll(dll_lock);
             if (r == 1) begin m_wa = 1; mstep = 10; end
             else if (r == 2) mfail(3); else mwait++;
           end
        10: begin m_clk = 0; mstep = 11; mwait = 0; end
        11: begin
              r = mpoll(clk_stable);
              if (r == 1) begin m_fl = 1; mstep = 12; mwait = 0; end
              else if (r == 2) mfail(4); else mwait++;
            end
        12: begin
              r = mpoll(flush_done);
              if (r == 1) begin m_fl = 0; m_clk = 1; mstep = 13; mwait = 0; end
              else if (r == 2) mfail(5); else mwait++;
            end
        13: begin
              r = mpoll(clk_stable);
              if (r == 1) begin m_done = 1; mstep = 0; end
              else if (r == 2) mfail(6); else mwait++;
            end
        default: mstep = 0;
      endcase
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && rel >= 2) begin
      bit bad = 0;
      if (busy != (mstep != 0)) begin bad = 1; $display("FAIL R11 busy: actual %0d expected %0d", busy, mstep != 0); end
      if (ddr_req != (mstep == 2) || hs_req != (mstep == 3)) begin bad = 1;
        $display("FAIL R4 req: actual %0d%0d expected %0d%0d", ddr_req, hs_req, mstep == 2, mstep == 3); end
      if (tb_en != m_tb) begin bad = 1; $display("FAIL R3 tb_en: actual %0d expected %0d", tb_en, m_tb); end
      if (int'(clk_div) != m_div) begin bad = 1; $display("FAIL R5 clk_div: actual %0d expected %0d", clk_div, m_div); end
      if (clk_en != m_clk) begin bad = 1; $display("FAIL R8 clk_en: actual %0d expected %0d", clk_en, m_clk); end
      if (hs400_sel != m_hs || cmd_clk_sel != m_cmd) begin bad = 1;
        $display("FAIL R5 hs/cmd: actual %0d%0d expected %0d%0d", hs400_sel, cmd_clk_sel, m_hs, m_cmd); end
      if (dll_en != m_dll || dll_fast != m_fs) begin bad = 1;
        $display("FAIL R6 dll: actual %0d%0d expected %0d%0d", dll_en, dll_fast, m_dll, m_fs); end
      if (wndw_adj != m_wa) begin bad = 1; $display("FAIL R6 wndw_adj: actual %0d expected %0d", wndw_adj, m_wa); end
      if (fifo_flush != m_fl) begin bad = 1; $display("FAIL R7 fifo_flush: actual %0d expected %0d", fifo_flush, m_fl); end
      if (flow_ctl != m_flow) begin bad = 1; $display("FAIL R2 flow_ctl: actual %0d expected %0d", flow_ctl, m_flow); end
      if (done != m_done) begin bad = 1; $display("FAIL R7 done: actual %0d expected %0d", done, m_done); end
      if (err != m_err || int'(err_code) != m_code) begin bad = 1;
        $display("FAIL R9 err/code: actual %0d/%0d expected %0d/%0d", err, err_code, m_err, m_code); end
      n_chk++;
      if (bad) n_fail++;
    end
  end

  // gate-to-configure interval monitor (R8)
  int t_off = 0, t_hs = 0;
  bit p_en = 1'b1, p_hs = 1'b0;
  always @(negedge clk) begin
    if (p_en && !clk_en && !hs400_sel) t_off = cyc;
    if (!p_hs && hs400_sel) t_hs = cyc;
    p_en = clk_en;
    p_hs = hs400_sel;
  end

  // ---------------- stimulus ----------------
  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_start(input int div, input bit rd);
    @(negedge clk);
    start = 1'b1; tune_div = DIV_W'(div); read_xfer = rd;
    @(negedge clk);
    start = 1'b0;
  endtask

  // waits for done or err; returns 1 on done, 2 on err, 0 on none
  task automatic wait_end(output int how);
    how = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin how = 1; break; end
      if (err) begin how = 2; break; end
    end
  endtask

  initial begin
    int how;
    do_reset();
    // R1 reset state
    chk(!busy && !ddr_req && !hs_req, "R1 idle outputs", busy, 0);
    chk(clk_en == 1'b1, "R1 clk_en", clk_en, 1);
    chk(int'(clk_div) == LS_DIV, "R1 clk_div", clk_div, LS_DIV);
    chk(!tb_en && !hs400_sel && !dll_en && !fifo_flush && !wndw_adj, "R1 control bits", tb_en, 0);
    chk(err_code == 3'd0 && !done && !err, "R1 err_code", err_code, 0);

    // run A: divider 4 -> exact 200 MHz, read, fast stability
    stb_lat = 3; lock_lat = 25; fl_lat = 5; ack_lat = 2; stuck = 0;
    do_start(4, 1'b1);
    chk(flow_ctl == 1'b1, "R2 flow_ctl follows read_xfer", flow_ctl, 1);
    @(negedge clk);
    chk(int'(clk_div) == LS_DIV && !tb_en, "R3 slow divider and tuning off", clk_div, LS_DIV);
    wait_end(how);
    chk(how == 1, "R7 done reached", how, 1);
    chk(int'(clk_div) == 4, "R5 captured divider restored", clk_div, 4);
    chk(dll_fast == 1'b1, "R6 fast chain at 200 MHz", dll_fast, 1);
    chk(tb_en && hs400_sel && cmd_clk_sel && wndw_adj && clk_en && !fifo_flush, "R7 final settings", 0, 1);
    chk(t_hs - t_off == 10, "R8 first poll passes", t_hs - t_off, 10);
    @(negedge clk);
    chk(!done && !busy, "R11 idle after done", busy, 0);

    // run B: divider 5 -> slow chain, no read, late stability, start while busy
    do_reset();
    stb_lat = 14; lock_lat = 3; fl_lat = 17; ack_lat = 7;
    do_start(5, 1'b0);
    chk(flow_ctl == 1'b0, "R2 flow_ctl cleared", flow_ctl, 0);
    repeat (20) @(negedge clk);
    do_start(9, 1'b1);
    wait_end(how);
    chk(how == 1, "R7 done with late status", how, 1);
    chk(int'(clk_div) == 5, "R2 busy start ignored", clk_div, 5);
    chk(flow_ctl == 1'b0, "R2 busy start left flow_ctl", flow_ctl, 0);
    chk(dll_fast == 1'b0, "R6 slow chain off 200 MHz", dll_fast, 0);
    chk(t_hs - t_off == 20, "R8 second poll passes", t_hs - t_off, 20);

    // timeout at each step
    for (int s = 1; s <= 6; s++) begin
      do_reset();
      stb_lat = 3; lock_lat = 4; fl_lat = 4; ack_lat = 1; stuck = s;
      do_start(4, 1'b1);
      wait_end(how);
      chk(how == 2, "R9 timeout raises err", how, 2);
      chk(int'(err_code) == s, "R9 err_code names step", err_code, s);
      chk(!fifo_flush && !busy, "R9 flush dropped and idle", fifo_flush, 0);
      repeat (5) @(negedge clk);
      chk(int'(err_code) == s && !done, "R10 err_code held while idle", err_code, s);
      stuck = 0;
    end
    // R10: next accepted start clears the code
    do_start(8, 1'b0);
    chk(err_code == 3'd0, "R10 err_code cleared by start", err_code, 0);
    wait_end(how);
    chk(how == 1, "R10 run after error completes", how, 1);

    repeat (3) @(negedge clk);
    report();
  end

endmodule